// File: doc/BRIEF.md
# Compare-and-Branch Fusion Unit

This unit sits right after instruction decode. Each cycle it takes up to `NIN` decoded instructions in program order. It turns them into a stream of micro-ops for the scheduler. Two adjacent instructions that form a genuine producer/consumer pair become a single micro-op:

- a compare directly followed by a conditional branch becomes one compare-and-branch micro-op;
- an address computation (base plus offset) whose result register is the address register of the very next load becomes one address-and-load micro-op, and the intermediate register is never written.

Every other instruction becomes exactly one micro-op. Independent neighbours, such as two unrelated ALU operations, are never merged, so the back end keeps them free to run in parallel.

An instruction that could head a pair but arrives in the last input lane cannot see its partner yet. It is parked for exactly one cycle and then joined with the first lane of the next group, or sent out alone. The output has `NIN+1` lanes, which is enough for a parked instruction plus a full group that cannot fuse. The block therefore never has to stall its producer. Outputs are registered, and a count reports how many reorder-buffer slots the cycle uses.

Top module: `fuse_detect`

## Requirements
- R1: A valid compare (kind 1) immediately followed by a valid conditional branch (kind 2) gives one micro-op of kind 6. Its dst, src1 and src2 come from the compare, and its imm and cc come from the branch.
- R2: A valid address computation (kind 3) immediately followed by a valid load (kind 4) whose src1 equals the address computation's dst gives one micro-op of kind 7. It has dst, src2 and cc of the load, src1 of the address computation, and imm equal to the sum of both imm fields modulo 2^16.
- R3: An address computation followed by a load whose src1 differs from the address computation's dst is not fused: two micro-ops are emitted, each a copy of its instruction.
- R4: Any other adjacent pair (for example two ALU operations, kind 0) is never fused. Each unfused instruction gives one micro-op whose kind and fields are copied unchanged.
- R5: Output lanes are filled from lane 0 without gaps, in program order. `out_cnt` equals the number of valid lanes, with a fused pair counting as one.
- R6: A compare or address computation in the last input lane that cannot fuse within its own cycle is withheld. It appears in lane 0 of the following cycle's output, fused with the next cycle's lane-0 instruction if they form a pair, otherwise alone.
- R7: A parked instruction is not fused when the next cycle's lane 0 is invalid, even if a later lane holds a matching partner.
- R8: A flush makes all output lanes invalid on the next cycle. It discards the parked instruction and the instructions presented in the flush cycle.
- R9: While reset is high and after it, before any input, all output lanes are invalid, `out_cnt` is 0 and nothing is parked.
- R10: Micro-ops of an instruction that is not parked appear on the outputs one clock after the instruction is presented. A cycle with no valid input and nothing parked produces no micro-ops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard parked and incoming instructions |
| in_valid | input | NIN | Per-lane instruction valid |
| in_kind | input | NIN x 3 | Instruction kind: 0 ALU, 1 compare, 2 cond. branch, 3 address calc, 4 load, 5 other |
| in_dst | input | NIN x 5 | Destination register |
| in_src1 | input | NIN x 5 | First source register (base for address calc and load) |
| in_src2 | input | NIN x 5 | Second source register |
| in_imm | input | NIN x 16 | Immediate: offset or branch target |
| in_cc | input | NIN x 4 | Condition code |
| out_valid | output | NIN+1 | Per-lane micro-op valid |
| out_kind | output | (NIN+1) x 3 | Micro-op kind: instruction kinds, plus 6 compare-and-branch and 7 address-and-load |
| out_dst | output | (NIN+1) x 5 | Micro-op destination |
| out_src1 | output | (NIN+1) x 5 | Micro-op first source |
| out_src2 | output | (NIN+1) x 5 | Micro-op second source |
| out_imm | output | (NIN+1) x 16 | Micro-op immediate |
| out_cc | output | (NIN+1) x 4 | Micro-op condition code |
| out_cnt | output | 2 | Reorder-buffer slots used this cycle |

## Verification
The directed cases cover the following failures:

- A compare parked across a cycle boundary must join a branch in the next lane 0. A design without parking emits two micro-ops.
- An invalid lane 0 between a parked compare and a branch must block fusion. A design that skips invalid lanes wrongly merges across the gap.
- An address/load pair whose registers do not match, and a pair of plain ALU operations, must stay separate. An over-eager fuser collapses them and undercounts slots.
- A flush while a compare is parked must drop it. A faulty design leaks it out a cycle later.
- A group that needs all three output lanes must fill every lane. Lane packing with gaps shows up here as a wrong count.

Random mixes over a small register set produce many accidental matches and near-misses.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam int KIND_W = 3;
  localparam int REG_W  = 5;
  localparam int IMM_W  = 16;
  localparam int CC_W   = 4;

  typedef enum logic [KIND_W-1:0] {
    K_ALU   = 3'd0,
    K_CMP   = 3'd1,
    K_BRC   = 3'd2,
    K_LEA   = 3'd3,
    K_LOAD  = 3'd4,
    K_OTHER = 3'd5,
    K_CMPBR = 3'd6,
    K_LDX   = 3'd7
  } kind_e;

  typedef struct packed {
    logic             v;
    kind_e            kind;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] src1;
    logic [REG_W-1:0] src2;
    logic [IMM_W-1:0] imm;
    logic [CC_W-1:0]  cc;
  } ins_t;
endpackage

// File: rtl/fuse_pair.sv
module fuse_pair
  import fuse_pkg::*;
(
  input  ins_t a,
  input  ins_t b,
  output logic fuse,
  output ins_t fused
);
  logic both_v;
  logic is_cmpbr;
  logic is_ldx;

  assign both_v   = a.v && b.v;
  assign is_cmpbr = both_v && (a.kind == K_CMP) && (b.kind == K_BRC);
  assign is_ldx   = both_v && (a.kind == K_LEA) && (b.kind == K_LOAD) && (b.src1 == a.dst);
  assign fuse     = is_cmpbr || is_ldx;

  always_comb begin
    fused = a;
    if (is_cmpbr) begin
      fused.kind = K_CMPBR;
      fused.imm  = b.imm;
      fused.cc   = b.cc;
    end else if (is_ldx) begin
      fused.kind = K_LDX;
      fused.dst  = b.dst;
      fused.src2 = b.src2;
      fused.imm  = a.imm + b.imm;
      fused.cc   = b.cc;
    end
  end
endmodule

// File: rtl/fuse_pack.sv
module fuse_pack
  import fuse_pkg::*;
#(
  parameter int N = 3,
  localparam int CNT_W = $clog2(N + 1)
) (
  input  ins_t             cand [N],
  output ins_t             lane [N],
  output logic [CNT_W-1:0] cnt
);
  always_comb begin
    logic [CNT_W-1:0] idx;
    idx = '0;
    for (int k = 0; k < N; k++) lane[k] = '0;
    for (int k = 0; k < N; k++) begin
      if (cand[k].v) begin
        lane[idx] = cand[k];
        idx = idx + CNT_W'(1);
      end
    end
    cnt = idx;
  end
endmodule

// File: rtl/fuse_detect.sv
module fuse_detect
  import fuse_pkg::*;
#(
  parameter int NIN = 2,
  localparam int NSEQ  = NIN + 1,
  localparam int NOUT  = NIN + 1,
  localparam int CNT_W = $clog2(NOUT + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        flush,
  input  logic [NIN-1:0]              in_valid,
  input  logic [NIN-1:0][KIND_W-1:0]  in_kind,
  input  logic [NIN-1:0][REG_W-1:0]   in_dst,
  input  logic [NIN-1:0][REG_W-1:0]   in_src1,
  input  logic [NIN-1:0][REG_W-1:0]   in_src2,
  input  logic [NIN-1:0][IMM_W-1:0]   in_imm,
  input  logic [NIN-1:0][CC_W-1:0]    in_cc,
  output logic [NOUT-1:0]             out_valid,
  output logic [NOUT-1:0][KIND_W-1:0] out_kind,
  output logic [NOUT-1:0][REG_W-1:0]  out_dst,
  output logic [NOUT-1:0][REG_W-1:0]  out_src1,
  output logic [NOUT-1:0][REG_W-1:0]  out_src2,
  output logic [NOUT-1:0][IMM_W-1:0]  out_imm,
  output logic [NOUT-1:0][CC_W-1:0]   out_cc,
  output logic [CNT_W-1:0]            out_cnt
);
  ins_t             hold_q, hold_d;
  logic             hold_v;
  ins_t             seq    [NSEQ];
  ins_t             pair_u [NIN];
  logic [NIN-1:0]   pair_f;
  logic [NIN-1:0]   take;
  ins_t             cand   [NSEQ];
  ins_t             lane   [NOUT];
  ins_t             lane_q [NOUT];
  logic [CNT_W-1:0] cnt_d, cnt_q;

  assign hold_v = hold_q.v;
  assign seq[0] = hold_q;

  // slot 0 of the window is the parked instruction, the rest are the inputs
  for (genvar i = 0; i < NIN; i++) begin : g_seq
    assign seq[i+1] = '{v: in_valid[i], kind: kind_e'(in_kind[i]), dst: in_dst[i],
                        src1: in_src1[i], src2: in_src2[i], imm: in_imm[i], cc: in_cc[i]};
  end

  for (genvar k = 0; k < NIN; k++) begin : g_pair
    fuse_pair u_pair (.a(seq[k]), .b(seq[k+1]), .fuse(pair_f[k]), .fused(pair_u[k]));
  end

  // earlier pair wins; a consumed tail cannot start another pair
  always_comb begin
    take[0] = pair_f[0];
    for (int k = 1; k < NIN; k++) take[k] = pair_f[k] && !take[k-1];
  end

  always_comb begin
    hold_d = '0;
    for (int j = 0; j < NSEQ; j++) cand[j] = seq[j];
    for (int j = 0; j < NIN; j++) begin
      if (take[j]) begin
        cand[j]   = pair_u[j];
        cand[j+1] = '0;
      end
    end
    if (!take[NIN-1] && seq[NSEQ-1].v &&
        (seq[NSEQ-1].kind == K_CMP || seq[NSEQ-1].kind == K_LEA)) begin
      hold_d         = seq[NSEQ-1];
      cand[NSEQ-1]   = '0;
    end
  end

  fuse_pack #(.N(NOUT)) u_pack (.cand(cand), .lane(lane), .cnt(cnt_d));

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      hold_q <= '0;
      cnt_q  <= '0;
      for (int l = 0; l < NOUT; l++) lane_q[l] <= '0;
    end else begin
      hold_q <= hold_d;
      cnt_q  <= cnt_d;
      for (int l = 0; l < NOUT; l++) lane_q[l] <= lane[l];
    end
  end

  for (genvar l = 0; l < NOUT; l++) begin : g_out
    assign out_valid[l] = lane_q[l].v;
    assign out_kind[l]  = lane_q[l].kind;
    assign out_dst[l]   = lane_q[l].dst;
    assign out_src1[l]  = lane_q[l].src1;
    assign out_src2[l]  = lane_q[l].src2;
    assign out_imm[l]   = lane_q[l].imm;
    assign out_cc[l]    = lane_q[l].cc;
  end
  assign out_cnt = cnt_q;
endmodule

// File: rtl/fuse_chk.sv
module fuse_chk #(
  parameter int NIN = 2,
  localparam int NOUT  = NIN + 1,
  localparam int CNT_W = $clog2(NOUT + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             flush,
  input logic [NIN-1:0]   in_valid,
  input logic [NOUT-1:0]  out_valid,
  input logic [CNT_W-1:0] out_cnt,
  input logic             hold_v
);
  AST_CNT_MATCH: assert property (@(posedge clk) disable iff (rst)
    out_cnt == CNT_W'($countones(out_valid))); // R5

  AST_NO_GAP: assert property (@(posedge clk) disable iff (rst)
    ((out_valid + NOUT'(1)) & out_valid) == '0); // R5

  AST_FLUSH_CLR: assert property (@(posedge clk) disable iff (rst)
    flush |=> (out_valid == '0) && !hold_v); // R8

  AST_RST_CLR: assert property (@(posedge clk)
    rst |=> (out_valid == '0) && (out_cnt == '0) && !hold_v); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (in_valid == '0 && !hold_v && !flush) |=> out_valid == '0); // R10

  AST_HOLD_ONCE: assert property (@(posedge clk) disable iff (rst)
    (hold_v && !in_valid[NIN-1]) |=> !hold_v); // R6
endmodule

bind fuse_detect fuse_chk #(.NIN(NIN)) chk_i (
  .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid),
  .out_valid(out_valid), .out_cnt(out_cnt), .hold_v(hold_v)
);

// File: tb/fuse_detect_tb_top.sv
module fuse_detect_tb_top;
  import fuse_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0;
  logic [1:0]            in_valid = '0;
  logic [1:0][2:0]       in_kind = '0;
  logic [1:0][4:0]       in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic [1:0][15:0]      in_imm = '0;
  logic [1:0][3:0]       in_cc = '0;
  logic [2:0]            out_valid;
  logic [2:0][2:0]       out_kind;
  logic [2:0][4:0]       out_dst, out_src1, out_src2;
  logic [2:0][15:0]      out_imm;
  logic [2:0][3:0]       out_cc;
  logic [1:0]            out_cnt;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  ins_t drv [2];
  ins_t mh;
  ins_t ex [3];
  int   ecnt;

  always #5 clk = ~clk;

  fuse_detect dut_i (
    .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid), .in_kind(in_kind),
    .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2), .in_imm(in_imm), .in_cc(in_cc),
    .out_valid(out_valid), .out_kind(out_kind), .out_dst(out_dst), .out_src1(out_src1),
    .out_src2(out_src2), .out_imm(out_imm), .out_cc(out_cc), .out_cnt(out_cnt)
  );

  function automatic ins_t mk(bit v, kind_e k, int d, int s1, int s2, int imm, int cc);
    ins_t x;
    x.v = v; x.kind = k; x.dst = 5'(d); x.src1 = 5'(s1); x.src2 = 5'(s2);
    x.imm = 16'(imm); x.cc = 4'(cc);
    return x;
  endfunction

  // merged micro-op per R1/R2, or v=0 when the pair does not qualify
  function automatic ins_t join2(ins_t a, ins_t b);
    ins_t r = '0;
    if (a.v && b.v && a.kind == K_CMP && b.kind == K_BRC)
      r = mk(1, K_CMPBR, a.dst, a.src1, a.src2, b.imm, b.cc);
    else if (a.v && b.v && a.kind == K_LEA && b.kind == K_LOAD && b.src1 == a.dst)
      r = mk(1, K_LDX, b.dst, a.src1, b.src2, (a.imm + b.imm) & 16'hffff, b.cc);
    return r;
  endfunction

  task automatic model(bit fl);
    ins_t s [3];
    ins_t nh = '0;
    for (int l = 0; l < 3; l++) ex[l] = '0;
    ecnt = 0;
    if (fl) begin mh = '0; return; end
    s[0] = mh; s[1] = drv[0]; s[2] = drv[1];
    for (int i = 0; i < 3; ) begin
      ins_t j;
      j = (i < 2) ? join2(s[i], s[i+1]) : ins_t'('0);
      if (!s[i].v) i++;
      else if (j.v) begin ex[ecnt] = j; ecnt++; i += 2; end
      else if (i == 2 && (s[i].kind == K_CMP || s[i].kind == K_LEA)) begin nh = s[i]; i++; end
      else begin ex[ecnt] = s[i]; ecnt++; i++; end
    end
    mh = nh;
  endtask

  task automatic compare(string tag);
    bit ok = 1;
    n_chk++;
    if (out_cnt != 2'(ecnt)) ok = 0;
    for (int l = 0; l < 3; l++) begin
      ins_t a;
      a = mk(out_valid[l], kind_e'(out_kind[l]), out_dst[l], out_src1[l], out_src2[l],
             out_imm[l], out_cc[l]);
      if (a.v != ex[l].v || (a.v && a != ex[l])) begin
        ok = 0;
        $display("FAIL %s lane %0d actual %h expected %h", tag, l, a, ex[l]);
      end
    end
    if (!ok) begin
      n_err++;
      $display("FAIL %s count actual %0d expected %0d", tag, out_cnt, ecnt);
    end
  endtask

  task automatic step(string tag, bit fl);
    flush = fl;
    for (int l = 0; l < 2; l++) begin
      in_valid[l] = drv[l].v; in_kind[l] = drv[l].kind; in_dst[l] = drv[l].dst;
      in_src1[l] = drv[l].src1; in_src2[l] = drv[l].src2; in_imm[l] = drv[l].imm;
      in_cc[l] = drv[l].cc;
    end
    model(fl);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic put(ins_t a, ins_t b);
    drv[0] = a; drv[1] = b;
  endtask

  function automatic ins_t rnd_ins();
    ins_t x;
    x = mk($urandom_range(0, 3) != 0, kind_e'($urandom_range(0, 5)), $urandom_range(0, 3),
           $urandom_range(0, 3), $urandom_range(0, 3), $urandom, $urandom_range(0, 15));
    return x;
  endfunction

  initial begin
    ins_t z;
    z = '0;
    mh = '0;
    void'($urandom(32'd1234));
    put(z, z);
    repeat (3) @(negedge clk);
    for (int l = 0; l < 3; l++) ex[l] = '0;
    ecnt = 0;
    compare("R9 reset state");
    rst = 1'b0;
    @(negedge clk);
    compare("R9 after reset");

    put(mk(1, K_CMP, 9, 3, 4, 0, 0), mk(1, K_BRC, 0, 0, 0, 'h1234, 5));
    step("R1 same-cycle compare+branch", 0);
    put(mk(1, K_LEA, 7, 2, 0, 'h10, 0), mk(1, K_LOAD, 8, 7, 6, 'h4, 3));
    step("R2 address+load fused", 0);
    put(mk(1, K_LEA, 7, 2, 0, 'hfff0, 0), mk(1, K_LOAD, 8, 7, 1, 'h20, 2));
    step("R2 offset wraps", 0);
    put(mk(1, K_LEA, 7, 2, 0, 'h10, 0), mk(1, K_LOAD, 8, 6, 0, 'h4, 0));
    step("R3 register mismatch not fused", 0);
    put(mk(1, K_ALU, 1, 2, 3, 5, 0), mk(1, K_ALU, 4, 5, 6, 7, 0));
    step("R4 independent ALU pair", 0);
    put(mk(1, K_ALU, 1, 2, 3, 0, 0), mk(1, K_CMP, 0, 1, 2, 0, 0));
    step("R6 compare parked", 0);
    put(mk(1, K_BRC, 0, 0, 0, 'h40, 9), mk(1, K_ALU, 3, 3, 3, 0, 0));
    step("R6 parked compare joins branch", 0);
    put(z, mk(1, K_CMP, 0, 1, 2, 0, 0));
    step("R6 park again", 0);
    put(z, mk(1, K_BRC, 0, 0, 0, 'h50, 1));
    step("R7 gap blocks fusion", 0);
    put(z, mk(1, K_LEA, 3, 1, 0, 8, 0));
    step("R6 park address", 0);
    put(mk(1, K_BRC, 0, 0, 0, 'h60, 2), mk(1, K_CMP, 1, 1, 1, 0, 0));
    step("R8 flush drops parked", 1);
    put(z, z);
    step("R8 nothing leaks after flush", 0);
    step("R10 idle cycle", 0);
    put(z, mk(1, K_LEA, 3, 1, 0, 8, 0));
    step("R6 park for three lanes", 0);
    put(mk(1, K_ALU, 1, 1, 1, 0, 0), mk(1, K_OTHER, 2, 2, 2, 0, 0));
    step("R5 three lanes used", 0);

    for (int n = 0; n < 400; n++) begin
      put(rnd_ins(), rnd_ins());
      step("R5 random mix", ($urandom_range(0, 19) == 0));
    end
    put(z, z);
    step("R10 drain", 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R10 watchdog actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule